// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Overflow Status

This block multiplies two 32-bit operands and adds the product to an accumulator, or subtracts it from the accumulator. It runs in one of three arithmetic modes: 32-bit signed, 64-bit signed and 64-bit unsigned. In the 64-bit modes the accumulator comes in as a pair of 32-bit words, and the result goes out as a pair of 32-bit words. The second factor is either a register word or a 9-bit immediate. The immediate is sign-extended in the signed modes and zero-extended in the unsigned mode.

Each accepted operation also produces two status values. The first is an overflow flag, computed by a rule that belongs to the mode. The second is an "advance overflow" flag, which reports that the top two bits of the result word disagree. The block also keeps sticky copies of both flags, and these accumulate across operations until they are cleared. Every flag sits in the top bit of its own word, so a core can merge the words into its status register.

The datapath is combinational. Its results and flags are registered and appear one cycle after the request.

Top module: `mac_flag_unit`

## Requirements
- R1: When `in_valid` is high at a clock edge, the results and flags of that operation appear after that edge, and `out_valid` is high for exactly that cycle. When no request is made, `out_valid` is low and every result and flag word keeps its value.
- R2: Mode 2'b00 is 32-bit signed. `res_lo` is the low word of `acc_lo ± a*b`, computed at full precision on sign-extended operands. `res_hi` is zero in this mode.
- R3: In mode 2'b00, overflow is set when the full-precision value is above 0x7FFFFFFF or below -0x80000000.
- R4: Mode 2'b01 is 64-bit signed. `{res_hi,res_lo}` is `{acc_hi,acc_lo} ± a*b` modulo 2^64, where the product is the full signed 64-bit product.
- R5: In mode 2'b01, overflow is set when the 64-bit signed add or subtract leaves the signed 64-bit range.
- R6: When mode bit 1 is set, the mode is 64-bit unsigned and the operands are zero-extended. On add, overflow is set when the carry leaves 64 bits. On subtract, overflow is set when the product is larger than the accumulator.
- R7: When `use_imm` is 1, `imm` replaces `b_reg`. It is sign-extended in modes 2'b00 and 2'b01 and zero-extended when mode bit 1 is set.
- R8: Advance overflow is bit 31 XOR bit 30 of the result word. That word is `res_lo` in 32-bit mode and `res_hi` in the 64-bit modes.
- R9: Each flag word carries its flag in bit 31, and all of its other bits are zero.
- R10: On every operation, each sticky flag ORs in its new flag value. An operation never clears a sticky flag.
- R11: `flag_clr` clears both sticky flags. If an operation arrives in the same cycle, the sticky flags take that operation's new values. A clear leaves the result words and the non-sticky flags unchanged.
- R12: A synchronous active-low reset sets every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation request |
| mode | input | 2 | 00 signed 32, 01 signed 64, 1x unsigned 64 |
| sub | input | 1 | 0 adds the product, 1 subtracts it |
| use_imm | input | 1 | Selects the immediate as second factor |
| imm | input | 9 | Immediate factor |
| a | input | 32 | First factor |
| b_reg | input | 32 | Register second factor |
| acc_lo | input | 32 | Accumulator low word |
| acc_hi | input | 32 | Accumulator high word (64-bit modes) |
| flag_clr | input | 1 | Clears the sticky flags |
| out_valid | output | 1 | Result ready pulse |
| res_lo | output | 32 | Result low word |
| res_hi | output | 32 | Result high word |
| v_word | output | 32 | Overflow flag in bit 31 |
| sv_word | output | 32 | Sticky overflow in bit 31 |
| av_word | output | 32 | Advance overflow in bit 31 |
| sav_word | output | 32 | Sticky advance overflow in bit 31 |

## Verification
The bench builds the unit with its defaults: a 32-bit word and a 9-bit immediate. With those widths the extreme operands 0x80000000, 0x7FFFFFFF and 0xFFFFFFFF reach both ends of every overflow rule. A 9-bit immediate reaches both its sign-extension path and its zero-extension path with values such as 0x100 and 0x1FF. Directed corner sweeps and seeded random operands cover all six mode and operation pairs, the immediate form, and sticky clear and update arriving alone or in the same cycle.

// File: rtl/mac_pkg.sv
package mac_pkg;
   typedef enum logic [1:0] {
      MD_S32  = 2'b00,
      MD_S64  = 2'b01,
      MD_U64  = 2'b10,
      MD_U64X = 2'b11
   } mac_mode_e;

   localparam int FLAG_CNT = 2;
endpackage

// File: rtl/mac_opsel.sv
module mac_opsel #(
   parameter int W     = 32,
   parameter int IMM_W = 9
) (
   input  logic             use_imm,
   input  logic             unsigned_md,
   input  logic [IMM_W-1:0] imm,
   input  logic [W-1:0]     b_reg,
   output logic [W-1:0]     b_eff
);
   localparam int PAD = W - IMM_W;

   logic [W-1:0] imm_ext;

   generate
      if (PAD > 0) begin : g_pad
         always_comb
            imm_ext = unsigned_md ? {{PAD{1'b0}}, imm}
                                  : {{PAD{imm[IMM_W-1]}}, imm};
      end else begin : g_nopad
         always_comb imm_ext = imm[W-1:0];
      end
   endgenerate

   assign b_eff = use_imm ? imm_ext : b_reg;
endmodule

// File: rtl/mac_core.sv
module mac_core
   import mac_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [1:0]   mode,
   input  logic         sub,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] acc_lo,
   input  logic [W-1:0] acc_hi,
   output logic [W-1:0] r_lo,
   output logic [W-1:0] r_hi,
   output logic         ovf,
   output logic         aovf
);
   localparam int DW = 2 * W;
   localparam int XW = 2 * W + 2;

   logic signed [XW-1:0] sx_a, sx_b, sx_acc, sx_full;
   logic [DW-1:0] acc64, sp, s_sum, up, u_sum;
   logic s32_ovf, s64_ovf, u64_ovf, x_res, x_op;

   always_comb begin
      sx_a   = {{(W+2){a[W-1]}}, a};
      sx_b   = {{(W+2){b[W-1]}}, b};
      sx_acc = {{(W+2){acc_lo[W-1]}}, acc_lo};
      sx_full = sub ? (sx_acc - sx_a * sx_b) : (sx_acc + sx_a * sx_b);
      // value fits when all bits from W-1 upward agree
      s32_ovf = (|sx_full[XW-1:W-1]) & ~(&sx_full[XW-1:W-1]);

      acc64 = {acc_hi, acc_lo};
      sp    = sx_a[DW-1:0] * sx_b[DW-1:0];
      s_sum = sub ? (acc64 - sp) : (acc64 + sp);
      x_res = s_sum[DW-1] ^ acc_hi[W-1];
      x_op  = acc_hi[W-1] ^ sp[DW-1];
      s64_ovf = sub ? (x_res & x_op) : (x_res & ~x_op);

      up    = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      u_sum = sub ? (acc64 - up) : (acc64 + up);
      u64_ovf = sub ? (up > acc64) : (u_sum < up);

      case (mode)
         MD_S32: begin
            r_lo = sx_full[W-1:0];
            r_hi = '0;
            ovf  = s32_ovf;
         end
         MD_S64: begin
            r_lo = s_sum[W-1:0];
            r_hi = s_sum[DW-1:W];
            ovf  = s64_ovf;
         end
         default: begin
            r_lo = u_sum[W-1:0];
            r_hi = u_sum[DW-1:W];
            ovf  = u64_ovf;
         end
      endcase
      aovf = (mode == MD_S32) ? (r_lo[W-1] ^ r_lo[W-2])
                              : (r_hi[W-1] ^ r_hi[W-2]);
   end
endmodule

// File: rtl/mac_flags.sv
module mac_flags
   import mac_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd,
   input  logic         clr,
   input  logic         ovf,
   input  logic         aovf,
   output logic [W-1:0] v_word,
   output logic [W-1:0] sv_word,
   output logic [W-1:0] av_word,
   output logic [W-1:0] sav_word
);
   logic [FLAG_CNT-1:0] nxt, cur, stk;

   assign nxt = {aovf, ovf};

   generate
      for (genvar i = 0; i < FLAG_CNT; i++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cur[i] <= 1'b0;
               stk[i] <= 1'b0;
            end else begin
               if (upd) cur[i] <= nxt[i];
               if (upd || clr) stk[i] <= (stk[i] & ~clr) | (upd & nxt[i]);
            end
         end
      end
   endgenerate

   assign v_word   = {cur[0], {(W-1){1'b0}}};
   assign av_word  = {cur[1], {(W-1){1'b0}}};
   assign sv_word  = {stk[0], {(W-1){1'b0}}};
   assign sav_word = {stk[1], {(W-1){1'b0}}};

   // R10
   sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk[0] && !clr) |=> stk[0]);
   // R10
   sticky_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && ovf) |=> (stk[0] && cur[0]));
   // R11
   clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !upd) |=> (stk == '0 && $stable(cur)));
endmodule

// File: rtl/mac_flag_unit.sv
module mac_flag_unit
   import mac_pkg::*;
#(
   parameter int W     = 32,
   parameter int IMM_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       mode,
   input  logic             sub,
   input  logic             use_imm,
   input  logic [IMM_W-1:0] imm,
   input  logic [W-1:0]     a,
   input  logic [W-1:0]     b_reg,
   input  logic [W-1:0]     acc_lo,
   input  logic [W-1:0]     acc_hi,
   input  logic             flag_clr,
   output logic             out_valid,
   output logic [W-1:0]     res_lo,
   output logic [W-1:0]     res_hi,
   output logic [W-1:0]     v_word,
   output logic [W-1:0]     sv_word,
   output logic [W-1:0]     av_word,
   output logic [W-1:0]     sav_word
);
   generate
      if (W < 4) begin : g_bad_w
         $error("mac_flag_unit: W must be at least 4");
      end
      if (IMM_W < 1 || IMM_W > W) begin : g_bad_imm
         $error("mac_flag_unit: IMM_W must lie in 1..W");
      end
   endgenerate

   logic [W-1:0] b_eff, c_lo, c_hi;
   logic         c_ovf, c_aovf;

   mac_opsel #(.W(W), .IMM_W(IMM_W)) u_opsel (
      .use_imm    (use_imm),
      .unsigned_md(mode[1]),
      .imm        (imm),
      .b_reg      (b_reg),
      .b_eff      (b_eff)
   );

   mac_core #(.W(W)) u_core (
      .mode  (mode),
      .sub   (sub),
      .a     (a),
      .b     (b_eff),
      .acc_lo(acc_lo),
      .acc_hi(acc_hi),
      .r_lo  (c_lo),
      .r_hi  (c_hi),
      .ovf   (c_ovf),
      .aovf  (c_aovf)
   );

   mac_flags #(.W(W)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (in_valid),
      .clr     (flag_clr),
      .ovf     (c_ovf),
      .aovf    (c_aovf),
      .v_word  (v_word),
      .sv_word (sv_word),
      .av_word (av_word),
      .sav_word(sav_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res_lo    <= '0;
         res_hi    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            res_lo <= c_lo;
            res_hi <= c_hi;
         end
      end
   end

   // R1
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(res_lo) && $stable(res_hi) && $stable(v_word)));
   // R2
   hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == MD_S32) |=> (res_hi == '0));
endmodule

// File: tb/mac_flag_unit_tb.sv
module mac_flag_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        sub = 1'b0;
   logic        use_imm = 1'b0;
   logic [8:0]  imm = '0;
   logic [31:0] a = '0, b_reg = '0, acc_lo = '0, acc_hi = '0;
   logic        flag_clr = 1'b0;
   logic        out_valid;
   logic [31:0] res_lo, res_hi, v_word, sv_word, av_word, sav_word;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   bit sv_m = 1'b0, sav_m = 1'b0;

   always #4 clk = ~clk;

   mac_flag_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .sub(sub),
      .use_imm(use_imm), .imm(imm), .a(a), .b_reg(b_reg), .acc_lo(acc_lo),
      .acc_hi(acc_hi), .flag_clr(flag_clr), .out_valid(out_valid),
      .res_lo(res_lo), .res_hi(res_hi), .v_word(v_word), .sv_word(sv_word),
      .av_word(av_word), .sav_word(sav_word)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic void model(input logic [1:0] md, input bit sb, input logic [31:0] x,
                                 input logic [31:0] y, input logic [31:0] al, input logic [31:0] ah,
                                 output logic [31:0] rl, output logic [31:0] rh,
                                 output bit v, output bit av);
      logic signed [127:0] sa, sy, sc, f;
      logic [127:0] ua, uy, uc, up, uf;
      if (md == 2'b00) begin
         sa = {{96{x[31]}}, x}; sy = {{96{y[31]}}, y}; sc = {{96{al[31]}}, al};
         f  = sb ? sc - sa * sy : sc + sa * sy;
         rl = f[31:0]; rh = '0;
         v  = (f > 128'sd2147483647) || (f < -128'sd2147483648);
      end else if (md == 2'b01) begin
         sa = {{96{x[31]}}, x}; sy = {{96{y[31]}}, y}; sc = {{64{ah[31]}}, ah, al};
         f  = sb ? sc - sa * sy : sc + sa * sy;
         rl = f[31:0]; rh = f[63:32];
         v  = (f > 128'sh7FFF_FFFF_FFFF_FFFF) || (f < -128'sh8000_0000_0000_0000);
      end else begin
         ua = {96'b0, x}; uy = {96'b0, y}; uc = {64'b0, ah, al};
         up = ua * uy;
         if (sb) begin uf = uc - up; v = up > uc; end
         else    begin uf = uc + up; v = uf[64]; end
         rl = uf[31:0]; rh = uf[63:32];
      end
      av = (md == 2'b00) ? (rl[31] ^ rl[30]) : (rh[31] ^ rh[30]);
   endfunction

   task automatic do_op(input logic [1:0] md, input bit sb, input bit ui, input logic [8:0] im,
                        input logic [31:0] x, input logic [31:0] y, input logic [31:0] al,
                        input logic [31:0] ah, input bit clr);
      logic [31:0] yb, rl, rh;
      bit v, av;
      string rt, vt, pre;
      @(negedge clk);
      in_valid = 1'b1; mode = md; sub = sb; use_imm = ui; imm = im;
      a = x; b_reg = y; acc_lo = al; acc_hi = ah; flag_clr = clr;
      @(negedge clk);
      in_valid = 1'b0; flag_clr = 1'b0;
      if (ui) yb = md[1] ? {23'b0, im} : {{23{im[8]}}, im};
      else    yb = y;
      model(md, sb, x, yb, al, ah, rl, rh, v, av);
      sv_m  = (clr ? 1'b0 : sv_m) | v;
      sav_m = (clr ? 1'b0 : sav_m) | av;
      rt  = (md == 2'b00) ? "R2" : (md == 2'b01) ? "R4" : "R6";
      vt  = (md == 2'b00) ? "R3" : (md == 2'b01) ? "R5" : "R6";
      pre = ui ? "R7 " : "";
      chk("R1 out_valid", {31'b0, out_valid}, 32'd1);
      chk({pre, rt, " res_lo"}, res_lo, rl);
      chk({pre, rt, " res_hi"}, res_hi, rh);
      chk({pre, vt, "/R9 v_word"}, v_word, {v, 31'b0});
      chk("R8/R9 av_word", av_word, {av, 31'b0});
      chk(clr ? "R11 sv_word" : "R10 sv_word", sv_word, {sv_m, 31'b0});
      chk(clr ? "R11 sav_word" : "R10 sav_word", sav_word, {sav_m, 31'b0});
   endtask

   function automatic logic [31:0] pick(input int k);
      case (k % 6)
         0: pick = 32'h0000_0000;
         1: pick = 32'h0000_0001;
         2: pick = 32'h7FFF_FFFF;
         3: pick = 32'h8000_0000;
         4: pick = 32'hFFFF_FFFF;
         default: pick = 32'h4000_0000;
      endcase
   endfunction

   function automatic logic [31:0] rval();
      int r;
      r = $urandom_range(0, 3);
      rval = (r == 0) ? pick($urandom_range(0, 5)) : $urandom;
   endfunction

   initial begin
      logic [31:0] keep_lo, keep_hi, keep_v;
      int unused_seed;
      unused_seed = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 out_valid", {31'b0, out_valid}, 32'd0);
      chk("R12 res_lo", res_lo, 32'd0);
      chk("R12 res_hi", res_hi, 32'd0);
      chk("R12 sv_word", sv_word, 32'd0);
      chk("R12 sav_word", sav_word, 32'd0);
      rst_n = 1'b1;

      // directed corners, every mode/op pair
      for (int md = 0; md < 3; md++)
         for (int sb = 0; sb < 2; sb++)
            for (int i = 0; i < 5; i++)
               for (int j = 0; j < 5; j++)
                  do_op(md[1:0], sb[0], 1'b0, 9'h0, pick(i), pick(j), pick(j + i), pick(4 - i), 1'b0);

      // R3 explicit: most negative squared overflows the 32-bit range
      do_op(2'b00, 1'b0, 1'b0, 9'h0, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0, 1'b0);
      // R7 immediate sign and zero extension
      do_op(2'b00, 1'b0, 1'b1, 9'h1FF, 32'd5, 32'hDEAD_BEEF, 32'd100, 32'h0, 1'b0);
      do_op(2'b01, 1'b1, 1'b1, 9'h100, 32'h7FFF_FFFF, 32'h0, 32'h0, 32'h0, 1'b0);
      do_op(2'b10, 1'b0, 1'b1, 9'h1FF, 32'hFFFF_FFFF, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      do_op(2'b11, 1'b1, 1'b1, 9'h100, 32'd3, 32'h0, 32'd10, 32'h0, 1'b0);

      // R11 clear alone: stickies drop, other state held
      do_op(2'b00, 1'b0, 1'b0, 9'h0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0, 32'h0, 1'b0);
      keep_lo = res_lo; keep_hi = res_hi; keep_v = v_word;
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
      sv_m = 1'b0; sav_m = 1'b0;
      chk("R11 sv_word after clear", sv_word, 32'd0);
      chk("R11 sav_word after clear", sav_word, 32'd0);
      chk("R11 res_lo kept", res_lo, keep_lo);
      chk("R11 v_word kept", v_word, keep_v);
      chk("R1 out_valid idle", {31'b0, out_valid}, 32'd0);
      @(negedge clk);
      chk("R1 res_hi held", res_hi, keep_hi);
      // R10 sticky kept through a clean operation
      do_op(2'b00, 1'b0, 1'b0, 9'h0, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0, 1'b0);
      do_op(2'b00, 1'b0, 1'b0, 9'h0, 32'd2, 32'd3, 32'd4, 32'h0, 1'b0);
      // R11 clear and overflowing update in the same cycle
      do_op(2'b01, 1'b0, 1'b0, 9'h0, 32'h8000_0000, 32'h8000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b1);
      // R11 clear with a clean update
      do_op(2'b10, 1'b0, 1'b0, 9'h0, 32'd1, 32'd1, 32'd1, 32'd0, 1'b1);

      // seeded random mix
      for (int n = 0; n < 400; n++) begin
         logic [1:0] md;
         md = 2'($urandom_range(0, 3));
         do_op(md, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
               9'($urandom), rval(), rval(), rval(), rval(), ($urandom_range(0, 15) == 0));
      end

      done = 1'b1;
   end

   initial begin : watchdog
      for (int c = 0; c < 150000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule